// File: doc/BRIEF.md
# Peripheral Interrupt Control Unit

This block gathers the event pulses of a timer peripheral into one interrupt request line. Five sources feed it with single-cycle pulses: two timer underflows, a clock alarm, a serial transfer finishing and an edge on an external flag pin. Each pulse latches a bit in an event flag register. A separate enable mask chooses which latched events may raise the request. Software reaches both registers through one register address. A read returns the flags. A write changes the mask.

A write to the mask either sets the enable bits it names or clears them, depending on its top data bit. When an enabled event is latched, an assertion is scheduled. One cycle later the summary bit of the flag byte sets and the active-low request output goes low. Only one assertion may be outstanding at a time. Reading the flag byte empties the flags, drops the request and cancels an assertion that has not yet taken effect. An event that arrives during that same read is still latched.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After a synchronous reset the flags, the mask and the summary bit are zero, no assertion is pending and `irq_n` is 1.
- R2: A pulse on `evt_in[i]` sets flag bit i. The bits are: bit0 timer A underflow, bit1 timer B underflow, bit2 alarm, bit3 serial done, bit4 external flag edge. A read at address 13 returns the flags in bits 4:0 and the summary in bit 7. Bits 6:5 always read 0.
- R3: A write to address 13 with data bit 7 = 1 ORs data bits 6:0 into the mask.
- R4: A write to address 13 with data bit 7 = 0 clears every mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R5: Suppose an event arrives in cycle T, its mask bit is enabled, and neither the summary bit nor a pending assertion is set. Then the assertion is pending after the edge that ends T. After the following edge, summary bit 7 reads 1 and `irq_n` is 0. An event whose mask bit is disabled sets its flag and does not assert the request.
- R6: A write that sets mask bits re-evaluates the flags already latched. If an enabled flag is present, the request asserts with the R5 timing, counted from the write cycle.
- R7: While an assertion is pending or the summary bit is set, further events only set their flags. `irq_n` stays low once it is low, until a read.
- R8: A read at address 13 clears all flags and the summary bit after its edge, so `irq_n` returns to 1. It also cancels a pending assertion, so a request scheduled in the previous cycle never asserts.
- R9: An event in the same cycle as a read at address 13 is latched after the clear. If it is enabled, it schedules a new assertion.
- R10: Reads and writes at any address other than 13 change neither the flags nor the mask, and they read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data. Combinational and valid while `bus_rd` is high. |
| evt_in | input | 5 | Single-cycle event pulses, in the bit order of R2 |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
Two functions can land on the same edge. An event pulse can coincide with a flag read, and a read can fall in the very cycle after a scheduled assertion. The bench provokes both with directed sequences, and constrained random traffic throws reads, mask writes and event pulses together at high density. Each cycle the bench compares the read byte and `irq_n` against a cycle model derived from the requirements. That model latches a colliding event after the clear and drops a cancelled assertion.

// File: rtl/evt_irq_pkg.sv
// Shared constants for the peripheral interrupt control unit.
// Assumes a 4-bit register address and an 8-bit data bus.
package evt_irq_pkg;
    localparam int NUM_SRC  = 5;   // event sources
    localparam int DATA_W   = 8;   // bus data width
    localparam int ADDR_W   = 4;   // bus address width
    localparam int SUM_BIT  = 7;   // summary / set-clear bit position
    localparam int MASK_W   = SUM_BIT; // mask holds data bits below SUM_BIT
    localparam logic [ADDR_W-1:0] IRQ_ADDR = 4'd13;
endpackage

// File: rtl/evt_flag_reg.sv
// Event flag register: latches event pulses and empties them on a clear.
// Assumes clr is a single-cycle strobe; events in the clear cycle survive.
module evt_flag_reg #(
    parameter int NUM_SRC = evt_irq_pkg::NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic [NUM_SRC-1:0] flags_q,
    output logic [NUM_SRC-1:0] flags_nxt
);
    // Next flags: clear first, then OR in this cycle's events.
    always_comb begin
        flags_nxt = (clr ? '0 : flags_q) | evt_in;
    end

    // Flag storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_nxt;
    end

    assert_evt_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in != '0) |=> ((flags_q & $past(evt_in)) == $past(evt_in)));
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt_in == '0) |=> (flags_q == '0));
    assert_evt_survives_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt_in != '0) |=> (flags_q == $past(evt_in)));
endmodule

// File: rtl/evt_mask_reg.sv
// Enable mask register: bit SUM_BIT of the write data selects set or clear.
// Assumes wr_en is already qualified by the address decode.
module evt_mask_reg #(
    parameter int DATA_W  = evt_irq_pkg::DATA_W,
    parameter int SUM_BIT = evt_irq_pkg::SUM_BIT,
    parameter int MASK_W  = evt_irq_pkg::MASK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [MASK_W-1:0] mask_q,
    output logic [MASK_W-1:0] mask_nxt,
    output logic              set_req
);
    logic [MASK_W-1:0] wbits;
    assign wbits   = wdata[MASK_W-1:0];
    assign set_req = wr_en & wdata[SUM_BIT];

    // Next mask: OR in on a set write, AND out on a clear write.
    always_comb begin
        mask_nxt = mask_q;
        if (wr_en) begin
            if (wdata[SUM_BIT]) mask_nxt = mask_q | wbits;
            else                mask_nxt = mask_q & ~wbits;
        end
    end

    // Mask storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_nxt;
    end

    assert_set_ors_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[SUM_BIT]) |=>
            ((mask_q & $past(wbits)) == $past(wbits)) && ((mask_q | $past(wbits)) == ($past(mask_q) | $past(wbits))));
    assert_clear_ands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[SUM_BIT]) |=>
            ((mask_q & $past(wbits)) == '0) && ((mask_q | $past(wbits)) == ($past(mask_q) | $past(wbits))));
    assert_no_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/evt_irq_sched.sv
// Request scheduler: one-cycle delayed assertion, one pending at a time,
// cancelled and cleared by a flag read. Drives the registered active-low line.
// Assumes hit is computed from the next mask and the next flags.
module evt_irq_sched (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic eval,
    input  logic hit,
    output logic summary_q,
    output logic pending_q,
    output logic irq_n
);
    logic sum_keep, pend_live, sched;

    // Surviving state after a possible read, and the new schedule decision.
    always_comb begin
        sum_keep  = summary_q & ~clr;
        pend_live = pending_q & ~clr;
        sched     = eval & hit & ~sum_keep & ~pend_live;
    end

    // Pending, summary and request line registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            summary_q <= 1'b0;
            irq_n     <= 1'b1;
        end else begin
            pending_q <= sched;
            summary_q <= sum_keep | pend_live;
            irq_n     <= ~(sum_keep | pend_live);
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_n && !pending_q && !summary_q));
    assert_fire_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !clr) |=> (summary_q && !irq_n));
    assert_single_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pending_q && summary_q));
    assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !clr) |=> !irq_n);
    assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (irq_n && !summary_q));
endmodule

// File: rtl/evt_irq_ctrl.sv
// Peripheral interrupt control unit top: decodes the shared flag/mask
// address, joins flag, mask and scheduler, and builds the read byte.
// Assumes bus_rd and bus_wr are single-cycle strobes.
module evt_irq_ctrl #(
    parameter int NUM_SRC = evt_irq_pkg::NUM_SRC,
    parameter int DATA_W  = evt_irq_pkg::DATA_W,
    parameter int ADDR_W  = evt_irq_pkg::ADDR_W,
    parameter int SUM_BIT = evt_irq_pkg::SUM_BIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic               irq_n
);
    localparam int MASK_W = SUM_BIT;
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(evt_irq_pkg::IRQ_ADDR);

    logic               sel, rd_clr, wr_mask, set_req, hit;
    logic [NUM_SRC-1:0] flags_q, flags_nxt;
    logic [MASK_W-1:0]  mask_q, mask_nxt;
    logic               summary_q, pending_q;

    // Address decode of the shared register.
    always_comb begin
        sel     = (bus_addr == HIT_ADDR);
        rd_clr  = sel & bus_rd;
        wr_mask = sel & bus_wr;
        hit     = |(mask_nxt & MASK_W'(flags_nxt));
    end

    evt_flag_reg #(.NUM_SRC(NUM_SRC)) i_flags (
        .clk(clk), .rst_n(rst_n), .clr(rd_clr), .evt_in(evt_in),
        .flags_q(flags_q), .flags_nxt(flags_nxt)
    );

    evt_mask_reg #(.DATA_W(DATA_W), .SUM_BIT(SUM_BIT), .MASK_W(MASK_W)) i_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_mask), .wdata(bus_wdata),
        .mask_q(mask_q), .mask_nxt(mask_nxt), .set_req(set_req)
    );

    evt_irq_sched i_sched (
        .clk(clk), .rst_n(rst_n), .clr(rd_clr),
        .eval((|evt_in) | set_req), .hit(hit),
        .summary_q(summary_q), .pending_q(pending_q), .irq_n(irq_n)
    );

    // Read byte: flags in low bits, summary at SUM_BIT, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (rd_clr) begin
            bus_rdata[NUM_SRC-1:0] = flags_q;
            bus_rdata[SUM_BIT]     = summary_q;
        end
    end

    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && evt_in == '0) |=> $stable(flags_q));
    assert_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |-> (bus_rdata == '0));
    assert_pend_from_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q |-> ((mask_q & MASK_W'(flags_q)) != '0) || !$past(rst_n) || $past(rd_clr) == 1'b0);
endmodule

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] evt_in = '0;
    logic       irq_n;

    int total = 0, bad = 0;
    // reference model state
    logic [4:0] m_flags = '0;
    logic [6:0] m_mask = '0;
    logic       m_sum = 1'b0, m_pend = 1'b0;

    always #5 clk = ~clk;

    evt_irq_ctrl i_evt_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .irq_n(irq_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_byte();
        return {m_sum, 2'b00, m_flags};
    endfunction

    // One cycle: drive at negedge, check read byte, advance model, check irq.
    task automatic tick(input logic [3:0] a, input logic w, input logic r,
                        input logic [7:0] d, input logic [4:0] e, input string tag);
        logic clr, wr13, eval, se, pe;
        logic [6:0] nmask;
        logic [4:0] nflags;
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; evt_in = e;
        #1;
        check({tag, " rdata R2 R10"}, bus_rdata, (r && a == 4'd13) ? m_byte() : 8'h00);
        clr   = r && a == 4'd13;
        wr13  = w && a == 4'd13;
        nmask = wr13 ? (d[7] ? (m_mask | d[6:0]) : (m_mask & ~d[6:0])) : m_mask;
        nflags = (clr ? 5'd0 : m_flags) | e;
        se = clr ? 1'b0 : m_sum;
        pe = clr ? 1'b0 : m_pend;
        eval = (|e) || (wr13 && d[7]);
        m_pend  = eval && (|(nmask & {2'b00, nflags})) && !se && !pe;
        m_sum   = se | pe;
        m_mask  = nmask;
        m_flags = nflags;
        @(posedge clk);
        @(negedge clk);
        check({tag, " irq_n R5 R7 R8"}, {7'd0, irq_n}, {7'd0, ~m_sum});
        bus_wr = 1'b0; bus_rd = 1'b0; evt_in = '0;
    endtask

    task automatic idle(input string tag);
        tick(4'd0, 1'b0, 1'b0, 8'h00, 5'h00, tag);
    endtask

    task automatic rd13(input logic [7:0] exp, input string tag);
        bus_addr = 4'd13; bus_rd = 1'b1; #1;
        check(tag, bus_rdata, exp);
        tick(4'd13, 1'b0, 1'b1, 8'h00, 5'h00, tag);
    endtask

    initial begin : watchdog
        #1_000_000;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
        rd13(8'h00, "R1 flags after reset");
        // R3/R5 enable timer A, event, request one cycle after scheduling
        tick(4'd13, 1'b1, 1'b0, 8'h81, 5'h00, "R3 set");
        tick(4'd0, 1'b0, 1'b0, 8'h00, 5'h01, "R5 event");
        check("R5 not yet asserted", {7'd0, irq_n}, 8'h01);
        idle("R5 fire");
        check("R5 asserted", {7'd0, irq_n}, 8'h00);
        rd13(8'h81, "R8 read summary");
        check("R8 irq released", {7'd0, irq_n}, 8'h01);
        // R4 clear mask, masked event only flags
        tick(4'd13, 1'b1, 1'b0, 8'h01, 5'h00, "R4 clear");
        tick(4'd0, 1'b0, 1'b0, 8'h00, 5'h01, "R4 event");
        idle("R4 wait"); idle("R4 wait2");
        check("R4 masked no irq", {7'd0, irq_n}, 8'h01);
        rd13(8'h01, "R2 masked flag bit0");
        // R6 set write re-evaluates latched flag
        tick(4'd0, 1'b0, 1'b0, 8'h00, 5'h02, "R6 event TB");
        tick(4'd13, 1'b1, 1'b0, 8'h82, 5'h00, "R6 set");
        check("R6 pending only", {7'd0, irq_n}, 8'h01);
        idle("R6 fire");
        check("R6 asserted", {7'd0, irq_n}, 8'h00);
        rd13(8'h82, "R6 read");
        // R8 cancel a pending assertion
        tick(4'd13, 1'b1, 1'b0, 8'h9F, 5'h00, "R8 enable all");
        tick(4'd0, 1'b0, 1'b0, 8'h00, 5'h04, "R8 alarm");
        rd13(8'h04, "R8 read cancels");
        idle("R8 w1"); idle("R8 w2");
        check("R8 cancelled", {7'd0, irq_n}, 8'h01);
        rd13(8'h00, "R8 empty");
        // R9 event in the read cycle survives and schedules
        bus_addr = 4'd13; bus_rd = 1'b1; evt_in = 5'h08; #1;
        check("R9 read during event", bus_rdata, 8'h00);
        tick(4'd13, 1'b0, 1'b1, 8'h00, 5'h08, "R9 collide");
        idle("R9 fire");
        check("R9 asserted", {7'd0, irq_n}, 8'h00);
        rd13(8'h88, "R9 flag kept");
        // R7 further events while pending / asserted only flag
        tick(4'd0, 1'b0, 1'b0, 8'h00, 5'h10, "R7 flag");
        tick(4'd0, 1'b0, 1'b0, 8'h00, 5'h01, "R7 during pending");
        tick(4'd0, 1'b0, 1'b0, 8'h00, 5'h02, "R7 during summary");
        check("R7 stays low", {7'd0, irq_n}, 8'h00);
        rd13(8'h93, "R7 accumulated");
        // R10 other addresses ignored
        tick(4'd5, 1'b1, 1'b0, 8'h1F, 5'h00, "R10 foreign write");
        tick(4'd4, 1'b0, 1'b1, 8'h00, 5'h00, "R10 foreign read");
        tick(4'd0, 1'b0, 1'b0, 8'h00, 5'h01, "R10 event");
        idle("R10 fire");
        check("R10 mask intact", {7'd0, irq_n}, 8'h00);
        rd13(8'h81, "R10 read");
        // R2 all sources, bits 6:5 read zero
        tick(4'd0, 1'b0, 1'b0, 8'h00, 5'h1F, "R2 all");
        idle("R2 fire");
        rd13(8'h9F, "R2 all bits");
        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] a;
            logic w, r;
            logic [7:0] d;
            logic [4:0] e;
            int sel;
            a = ($urandom % 4 != 0) ? 4'd13 : 4'($urandom % 16);
            sel = $urandom % 8;
            w = (sel == 0);
            r = (sel == 1) || (sel == 2);
            d = 8'($urandom);
            e = '0;
            for (int b = 0; b < 5; b++) e[b] = ($urandom % 10 == 0);
            tick(a, w, r, d, e, "rand R5 R7 R8 R9");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule